// File: doc/BRIEF.md
# Sleep and Clock-Gating Controller

This block decides which clock domains of a small processor system are allowed to run. While the system is active, the CPU may ask for sleep with a one-cycle strobe. If sleep is enabled and the selected mode code is valid, the controller enters one of five sleep modes. Each mode stops its own set of domains: CPU, nonvolatile memory (NVM), peripheral and real-time counter (RTC). Each mode also accepts its own set of wake sources. Standby-class modes also ask the oscillators to stay up, so that wake-up is faster.

On a qualified wake event the controller goes to a hold phase. During the hold the CPU clock stays off for a fixed four cycles. The controller then returns to active and pulses a wake indication, so that the interrupt handler can run. A software-written power-reduction mask turns off the clocks of single peripherals, and it takes effect whenever the peripheral domain runs. Any NVM programming operation that is still in progress keeps the memory clock on until it ends. Reset always brings the controller back to active.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: Mode codes on `sleep_mode` are 0 idle, 2 power-down, 3 power-save, 6 standby and 7 extended standby. A strobe with code 1, 4 or 5 is ignored. A strobe seen outside the active state has no effect.
- R2: A strobe while `sleep_en` is 1 and the code is valid moves `status` to sleeping after that clock edge. A strobe while `sleep_en` is 0 leaves the controller active.
- R3: In idle, `clk_en_cpu` is 0 and `clk_en_per` and `clk_en_rtc` are 1. `irq_any`, or any synchronized asynchronous source, wakes the controller.
- R4: In a sleep state, `clk_en_nvm` follows `nvm_busy`, so that a programming operation still in progress keeps the memory clock until it finishes. In the other states `clk_en_nvm` is 1.
- R5: In power-down, all four domain enables are 0 (NVM aside while it is busy). Only the two-wire address match, the asynchronous port interrupt and the USB resume input wake the controller. `irq_any` and the RTC interrupt are ignored.
- R6: Power-save behaves like power-down, except that `clk_en_rtc` stays 1 and the RTC interrupt is also a wake source.
- R7: Standby gates and wakes like power-down, and extended standby like power-save. In both, `osc_keep` is 1 while sleeping. In all other cases it is 0.
- R8: The asynchronous wake inputs pass through two flops. An input first sampled high at edge k moves `status` to wake-hold at edge k+2. `irq_any` acts at edge k itself.
- R9: Wake-hold lasts exactly four cycles with `clk_en_cpu` 0. Then `status` returns to active and `wake_pulse` is 1 for one cycle.
- R10: A synchronous low `rst_n` forces active, clears the power-reduction mask and gives no `wake_pulse`. This holds in any state, sleep included.
- R11: `prr_wr` loads `prr_wdata` into the mask. `per_clk_en[i]` is `clk_en_per` with mask bit i cleared, and applies in active, idle and wake-hold.
- R12: `status` encodes the state as 0 active, 1 sleeping and 2 wake-hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_strobe | input | 1 | One-cycle sleep request from the CPU |
| sleep_en | input | 1 | Software sleep enable |
| sleep_mode | input | 3 | Software-selected sleep mode code |
| nvm_busy | input | 1 | NVM programming in progress |
| irq_any | input | 1 | Any enabled synchronous interrupt pending |
| twi_match_async | input | 1 | Two-wire address match, asynchronous |
| port_irq_async | input | 1 | Asynchronous pin-change interrupt |
| usb_resume_async | input | 1 | USB resume event, asynchronous |
| rtc_irq_async | input | 1 | RTC interrupt from its own clock domain |
| prr_wr | input | 1 | Write strobe for the power-reduction mask |
| prr_wdata | input | NUM_PERIPH | New power-reduction mask |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_nvm | output | 1 | NVM clock enable |
| clk_en_per | output | 1 | Peripheral domain clock enable |
| clk_en_rtc | output | 1 | RTC domain clock enable |
| per_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| osc_keep | output | 1 | Keep oscillators running while asleep |
| wake_pulse | output | 1 | One-cycle pulse when execution resumes |
| status | output | 2 | Controller state code |

## Verification
The hardest case to reach is a wake source that arrives in a mode that must ignore it, while its synchronized copy is still in the two-flop pipe. The stimulus raises `irq_any` and the RTC interrupt in power-down and lets both drain through the synchronizer. It then raises a valid source for a single cycle, so that the exact two-edge latency and the four-cycle hold are both seen at the ports. A strobe placed inside wake-hold and a reset placed in mid-sleep cover the remaining paths out of the non-active states.

// File: rtl/slpc_pkg.sv
// Shared types and mode decode for the sleep and clock-gating controller.
// Assumes three-bit mode codes. Codes not listed below are treated as reserved.
package slpc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'b00,
        ST_SLEEP  = 2'b01,
        ST_HOLD   = 2'b10
    } slp_state_t;

    localparam logic [2:0] MODE_IDLE  = 3'd0;
    localparam logic [2:0] MODE_PDOWN = 3'd2;
    localparam logic [2:0] MODE_PSAVE = 3'd3;
    localparam logic [2:0] MODE_STBY  = 3'd6;
    localparam logic [2:0] MODE_XSTBY = 3'd7;

    // Bit positions of the asynchronous wake sources in the synchronized vector
    localparam int WK_TWI    = 0;
    localparam int WK_PORT   = 1;
    localparam int WK_USB    = 2;
    localparam int WK_RTC    = 3;
    localparam int NUM_ASYNC = 4;

    // True for the five mode codes that may be entered
    function automatic logic mode_valid(input logic [2:0] m);
        return (m == MODE_IDLE) || (m == MODE_PDOWN) || (m == MODE_PSAVE) ||
               (m == MODE_STBY) || (m == MODE_XSTBY);
    endfunction

    // True for the modes in which the real-time counter domain keeps its clock
    function automatic logic mode_rtc_on(input logic [2:0] m);
        return (m == MODE_IDLE) || (m == MODE_PSAVE) || (m == MODE_XSTBY);
    endfunction

    // True for the modes that keep the oscillators running
    function automatic logic mode_osc_on(input logic [2:0] m);
        return (m == MODE_STBY) || (m == MODE_XSTBY);
    endfunction

endpackage

// File: rtl/slpc_sync.sv
// Multi-stage synchronizer for a vector of asynchronous single-bit events.
// Assumes that each bit is an independent level, so bits need no mutual coherence.
// The stage count is a parameter, and the latency is STAGES clock edges.
module slpc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage settles the value of the stage before it
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/slpc_fsm.sv
// Sleep state machine: enters sleep on a qualified strobe, wakes on the
// wake sources allowed by the latched mode, then holds the CPU for HOLD_CYC
// cycles before it returns to active with a one-cycle wake pulse.
// Assumes that wake_sync is already synchronized to clk.
module slpc_fsm
    import slpc_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_strobe,
    input  logic                 sleep_en,
    input  logic [2:0]           sleep_mode,
    input  logic                 irq_any,
    input  logic [NUM_ASYNC-1:0] wake_sync,
    output slp_state_t           state_q,
    output logic [2:0]           mode_q,
    output logic                 wake_pulse
);

    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] hold_cnt;
    logic          enter_req;
    logic          async_hit;
    logic          wake_hit;
    logic          chk_armed;

    // Sleep entry needs the strobe, the enable bit and a mode code that exists
    assign enter_req = sleep_strobe && sleep_en && mode_valid(sleep_mode);

    assign async_hit = wake_sync[WK_TWI] | wake_sync[WK_PORT] | wake_sync[WK_USB];

    // Pick the wake sources that the latched mode accepts
    always_comb begin
        case (mode_q)
            MODE_IDLE:              wake_hit = irq_any | async_hit | wake_sync[WK_RTC];
            MODE_PDOWN, MODE_STBY:  wake_hit = async_hit;
            MODE_PSAVE, MODE_XSTBY: wake_hit = async_hit | wake_sync[WK_RTC];
            default:                wake_hit = 1'b0;
        endcase
    end

    // State, mode latch, hold counter and wake pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_ACTIVE;
            mode_q     <= MODE_IDLE;
            hold_cnt   <= '0;
            wake_pulse <= 1'b0;
        end else begin
            wake_pulse <= 1'b0;
            case (state_q)
                ST_ACTIVE: begin
                    if (enter_req) begin
                        state_q <= ST_SLEEP;
                        mode_q  <= sleep_mode;
                    end
                end
                ST_SLEEP: begin
                    if (wake_hit) begin
                        state_q  <= ST_HOLD;
                        hold_cnt <= '0;
                    end
                end
                ST_HOLD: begin
                    if (hold_cnt == HOLD_LAST) begin
                        state_q    <= ST_ACTIVE;
                        wake_pulse <= 1'b1;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                default: state_q <= ST_ACTIVE;
            endcase
        end
    end

    // Arms the checks one cycle after reset so that $past sees reset values
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    // R1: sleep is entered only from the active state
    p_enter_from_active_r1: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
        (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |-> $past(state_q) == ST_ACTIVE);

    // R2: a strobe with sleep disabled keeps the controller active
    p_strobe_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && sleep_strobe && !sleep_en) |=> state_q == ST_ACTIVE);

    // R9: the last hold cycle leads to active with the wake pulse
    p_hold_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && hold_cnt == HOLD_LAST) |=> (state_q == ST_ACTIVE && wake_pulse));

    // R9: the wake pulse only follows a hold cycle
    p_pulse_after_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
        wake_pulse |-> $past(state_q) == ST_HOLD);

endmodule

// File: rtl/slpc_gate.sv
// Clock-enable decode for the four domains, plus the per-peripheral
// power-reduction mask. Assumes that mode_q is only meaningful while sleeping.
module slpc_gate
    import slpc_pkg::*;
#(
    parameter int NUM_PERIPH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  slp_state_t            state_q,
    input  logic [2:0]            mode_q,
    input  logic                  nvm_busy,
    input  logic                  prr_wr,
    input  logic [NUM_PERIPH-1:0] prr_wdata,
    output logic                  clk_en_cpu,
    output logic                  clk_en_nvm,
    output logic                  clk_en_per,
    output logic                  clk_en_rtc,
    output logic                  osc_keep,
    output logic [NUM_PERIPH-1:0] per_clk_en
);

    logic [NUM_PERIPH-1:0] prr_q;
    logic                  asleep;

    assign asleep = (state_q == ST_SLEEP);

    // Power-reduction mask register, written by software
    always_ff @(posedge clk) begin
        if (!rst_n)      prr_q <= '0;
        else if (prr_wr) prr_q <= prr_wdata;
    end

    // Domain enables chosen by the state and the latched mode
    always_comb begin
        clk_en_cpu = (state_q == ST_ACTIVE);
        clk_en_nvm = !asleep || nvm_busy;
        clk_en_per = !asleep || (mode_q == MODE_IDLE);
        clk_en_rtc = !asleep || mode_rtc_on(mode_q);
        osc_keep   = asleep && mode_osc_on(mode_q);
    end

    genvar i;
    generate
        for (i = 0; i < NUM_PERIPH; i++) begin : g_pclk
            // Each peripheral runs when its domain runs and its mask bit is clear
            assign per_clk_en[i] = clk_en_per && !prr_q[i];
        end
    endgenerate

    // R4: a busy NVM always keeps its clock
    p_nvm_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_busy |-> clk_en_nvm);

    // R11: the mask changes only when written
    p_prr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !prr_wr |=> $stable(prr_q));

endmodule

// File: rtl/sleep_clk_ctrl.sv
// Top of the sleep and clock-gating controller. It synchronizes the
// asynchronous wake inputs, runs the sleep state machine and decodes the
// clock enables. Assumes that all synchronous inputs share clk.
module sleep_clk_ctrl
    import slpc_pkg::*;
#(
    parameter int NUM_PERIPH  = 8,
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_strobe,
    input  logic                  sleep_en,
    input  logic [2:0]            sleep_mode,
    input  logic                  nvm_busy,
    input  logic                  irq_any,
    input  logic                  twi_match_async,
    input  logic                  port_irq_async,
    input  logic                  usb_resume_async,
    input  logic                  rtc_irq_async,
    input  logic                  prr_wr,
    input  logic [NUM_PERIPH-1:0] prr_wdata,
    output logic                  clk_en_cpu,
    output logic                  clk_en_nvm,
    output logic                  clk_en_per,
    output logic                  clk_en_rtc,
    output logic [NUM_PERIPH-1:0] per_clk_en,
    output logic                  osc_keep,
    output logic                  wake_pulse,
    output logic [1:0]            status
);

    logic [NUM_ASYNC-1:0] wake_raw;
    logic [NUM_ASYNC-1:0] wake_sync;
    slp_state_t           state_q;
    logic [2:0]           mode_q;

    // Gather the asynchronous sources in their package bit order
    always_comb begin
        wake_raw          = '0;
        wake_raw[WK_TWI]  = twi_match_async;
        wake_raw[WK_PORT] = port_irq_async;
        wake_raw[WK_USB]  = usb_resume_async;
        wake_raw[WK_RTC]  = rtc_irq_async;
    end

    slpc_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (wake_raw),
        .dout  (wake_sync)
    );

    slpc_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_strobe (sleep_strobe),
        .sleep_en     (sleep_en),
        .sleep_mode   (sleep_mode),
        .irq_any      (irq_any),
        .wake_sync    (wake_sync),
        .state_q      (state_q),
        .mode_q       (mode_q),
        .wake_pulse   (wake_pulse)
    );

    slpc_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .mode_q     (mode_q),
        .nvm_busy   (nvm_busy),
        .prr_wr     (prr_wr),
        .prr_wdata  (prr_wdata),
        .clk_en_cpu (clk_en_cpu),
        .clk_en_nvm (clk_en_nvm),
        .clk_en_per (clk_en_per),
        .clk_en_rtc (clk_en_rtc),
        .osc_keep   (osc_keep),
        .per_clk_en (per_clk_en)
    );

    assign status = state_q;

    // R5: deep power-down leaves every domain dark while the NVM is idle
    p_pdown_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b01 && mode_q == MODE_PDOWN && !nvm_busy) |->
        (!clk_en_cpu && !clk_en_nvm && !clk_en_per && !clk_en_rtc && per_clk_en == '0));

    // R7: the oscillators are only flagged while sleeping
    p_osc_only_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        osc_keep |-> status == 2'b01);

    // R9: the CPU never runs outside the active state
    p_cpu_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b00) |-> !clk_en_cpu);

endmodule

// File: tb/tb_sleep_clk_ctrl.sv
// Scoreboard bench: the driver steps a model built from the requirements and
// queues the expected outputs, and the monitor compares them after each edge.
module tb_sleep_clk_ctrl;

    localparam int NP = 8;
    localparam int W  = 8 + NP;

    logic clk = 1'b0;
    logic rst_n = 1'b0, strobe = 1'b0, en = 1'b0, nvm_busy = 1'b0, irq_any = 1'b0;
    logic a_twi = 1'b0, a_port = 1'b0, a_usb = 1'b0, a_rtc = 1'b0, prr_wr = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic [NP-1:0] prr_wd = '0;
    logic cpu, nvm, per, rtc, osc, wk;
    logic [NP-1:0] pclk;
    logic [1:0]    status;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    string         tq[$];
    logic [W-1:0]  eq[$];

    // bench model state
    logic [1:0]    m_st = 2'd0;
    logic [2:0]    m_md = 3'd0;
    logic [NP-1:0] m_prr = '0;
    int            m_hc = 0;
    logic          m_wk = 1'b0;
    logic [3:0]    m_s1 = '0, m_s2 = '0;

    always #5 clk = ~clk;

    sleep_clk_ctrl #(.NUM_PERIPH(NP)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_strobe(strobe), .sleep_en(en),
        .sleep_mode(mode), .nvm_busy(nvm_busy), .irq_any(irq_any),
        .twi_match_async(a_twi), .port_irq_async(a_port),
        .usb_resume_async(a_usb), .rtc_irq_async(a_rtc),
        .prr_wr(prr_wr), .prr_wdata(prr_wd),
        .clk_en_cpu(cpu), .clk_en_nvm(nvm), .clk_en_per(per), .clk_en_rtc(rtc),
        .per_clk_en(pclk), .osc_keep(osc), .wake_pulse(wk), .status(status)
    );

    // R1 codes: 0,2,3,6,7 valid
    function automatic logic valid_code(input logic [2:0] m);
        return m == 3'd0 || m == 3'd2 || m == 3'd3 || m == 3'd6 || m == 3'd7;
    endfunction

    // R3, R5, R6, R7 wake rules; s bits: 0 twi, 1 port, 2 usb, 3 rtc
    function automatic logic wake_ok(input logic [2:0] m, input logic irq, input logic [3:0] s);
        logic pins;
        pins = s[0] | s[1] | s[2];
        case (m)
            3'd0:       return irq | (|s);
            3'd2, 3'd6: return pins;
            3'd3, 3'd7: return pins | s[3];
            default:    return 1'b0;
        endcase
    endfunction

    // Advances the model by one edge, queues the expectation, waits a cycle
    task automatic cyc(input string tag);
        logic sl;
        logic e_per;
        if (!rst_n) begin
            m_st = 2'd0; m_md = 3'd0; m_prr = '0; m_hc = 0; m_wk = 1'b0;
            m_s1 = '0; m_s2 = '0;
        end else begin
            m_wk = 1'b0;
            case (m_st)
                2'd0: if (strobe && en && valid_code(mode)) begin m_st = 2'd1; m_md = mode; end
                2'd1: if (wake_ok(m_md, irq_any, m_s2)) begin m_st = 2'd2; m_hc = 0; end
                default: if (m_hc == 3) begin m_st = 2'd0; m_wk = 1'b1; end
                         else m_hc++;
            endcase
            if (prr_wr) m_prr = prr_wd;
            m_s2 = m_s1;
            m_s1 = {a_rtc, a_usb, a_port, a_twi};
        end
        sl    = (m_st == 2'd1);
        e_per = !sl || m_md == 3'd0;
        tq.push_back(tag);
        eq.push_back({m_st, m_st == 2'd0, !sl || nvm_busy, e_per,
                      !sl || m_md == 3'd0 || m_md == 3'd3 || m_md == 3'd7,
                      sl && (m_md == 3'd6 || m_md == 3'd7), m_wk,
                      e_per ? ~m_prr : {NP{1'b0}}});
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(tag);
    endtask

    // Monitor: compares each queued expectation just after its edge
    always @(posedge clk) begin
        #2;
        if (eq.size() > 0) begin
            logic [W-1:0] exp_v, act_v;
            string t;
            exp_v = eq.pop_front();
            t     = tq.pop_front();
            act_v = {status, cpu, nvm, per, rtc, osc, wk, pclk};
            tests++;
            if (act_v !== exp_v) begin
                fails++;
                $display("FAIL %s at %0t: actual %h expected %h", t, $time, act_v, exp_v);
            end
        end
    end

    // Watchdog: ends a hung run as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        run(3, "R10 reset state");
        rst_n = 1'b1;
        run(2, "R12 active code");
        prr_wr = 1'b1; prr_wd = 8'hA5; run(1, "R11 mask write");
        prr_wr = 1'b0; run(1, "R11 mask held");
        // R2: strobe with sleep disabled
        en = 1'b0; mode = 3'd0; strobe = 1'b1; run(1, "R2 disabled strobe");
        strobe = 1'b0; run(2, "R2 stays active");
        // R1: reserved code
        en = 1'b1; mode = 3'd4; strobe = 1'b1; run(1, "R1 reserved code");
        strobe = 1'b0; run(1, "R1 reserved code");
        // R3/R4: idle with NVM draining
        mode = 3'd0; nvm_busy = 1'b1; strobe = 1'b1; run(1, "R3 idle entry");
        strobe = 1'b0; run(2, "R4 nvm busy");
        nvm_busy = 1'b0; run(2, "R4 nvm released");
        irq_any = 1'b1; run(1, "R3 irq wake");
        irq_any = 1'b0; strobe = 1'b1; run(1, "R1 strobe in hold");
        strobe = 1'b0; run(3, "R9 hold");
        run(2, "R9 wake pulse");
        // R5/R8: power-down ignores irq and rtc, wakes on twi after two edges
        mode = 3'd2; strobe = 1'b1; run(1, "R5 pdown entry");
        strobe = 1'b0; irq_any = 1'b1; a_rtc = 1'b1; run(6, "R5 ignored sources");
        irq_any = 1'b0; a_rtc = 1'b0; run(3, "R5 drain");
        a_twi = 1'b1; run(1, "R8 twi sampled");
        a_twi = 1'b0; run(2, "R8 sync latency");
        run(5, "R9 hold and pulse");
        // R6: power-save wakes on rtc
        mode = 3'd3; strobe = 1'b1; run(1, "R6 psave entry");
        strobe = 1'b0; run(2, "R6 rtc on");
        a_rtc = 1'b1; run(1, "R6 rtc wake");
        a_rtc = 1'b0; run(7, "R6 wake path");
        // R7: standby ignores rtc, wakes on usb
        mode = 3'd6; strobe = 1'b1; run(1, "R7 standby entry");
        strobe = 1'b0; a_rtc = 1'b1; run(4, "R7 standby rtc ignored");
        a_rtc = 1'b0; run(3, "R7 standby");
        a_usb = 1'b1; run(1, "R7 usb wake");
        a_usb = 1'b0; run(7, "R7 wake path");
        // R7: extended standby wakes on port
        mode = 3'd7; strobe = 1'b1; run(1, "R7 xstandby entry");
        strobe = 1'b0; run(2, "R7 xstandby");
        a_port = 1'b1; run(1, "R7 port wake");
        a_port = 1'b0; run(7, "R7 wake path");
        // R11: mask applied in idle
        prr_wr = 1'b1; prr_wd = 8'h3C; run(1, "R11 new mask");
        prr_wr = 1'b0; mode = 3'd0; strobe = 1'b1; run(1, "R11 idle mask");
        strobe = 1'b0; run(2, "R11 idle mask");
        irq_any = 1'b1; run(1, "R11 wake");
        irq_any = 1'b0; run(5, "R11 wake path");
        // R10: reset during power-down
        mode = 3'd2; strobe = 1'b1; run(1, "R10 pdown entry");
        strobe = 1'b0; run(2, "R10 asleep");
        rst_n = 1'b0; run(1, "R10 reset in sleep");
        rst_n = 1'b1; run(3, "R10 after reset");
        @(posedge clk); #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule